// File: doc/BRIEF.md
# Half-Duplex Control/Response Serial Master

This block is the master side of a half-duplex serial link. In each frame it shifts an 8-bit control byte out to a slave, MSB first. It then leaves one idle serial-clock period so the slave can decode the byte, and clocks in a response word of 4 to 16 bits. The control byte comes in through a valid/ready handshake. The response length, the serial-clock half-period and a continuous-mode flag are static configuration inputs. Each received word is right-aligned in a 16-bit output and announced by a one-cycle valid strobe.

In single mode every frame is closed by raising the active-low frame select. In continuous mode, if the next control byte is already waiting when the last response bit has been taken, the select stays low. That byte then starts on the very next falling edge of the serial clock.

Top module: `hdx_serial_master`

## Requirements
- R1: Out of reset and whenever no frame is in progress, the serial clock is low, the active-low select is high, transmit data is low and the valid strobe is low.
- R2: The command input is ready whenever the engine is idle. One system cycle after a byte is accepted, the select is low and transmit data carries bit 7 of that byte.
- R3: Every low and high phase of the serial clock lasts `div_i` system cycles, and a `div_i` of zero is treated as one. The first rising edge comes `div_i` cycles after the select falls.
- R4: The control byte appears on transmit data MSB first, one bit per serial period. Bits change only on falling edges, so the first eight rising edges see bits 7 down to 0.
- R5: The ninth serial period is a wait state with no sampling. Transmit data stays low from the eighth falling edge to the end of the frame, and the receive line is ignored during the control and wait periods.
- R6: The response length is taken from `resp_len_i` when a frame starts and is clamped to the range 4..16. A frame has 9 + N rising edges for a length of N.
- R7: Response bits are sampled on rising edges 10 through 9 + N, first bit most significant. The word is right-aligned and zero-extended to 16 bits.
- R8: In single mode, the select rises 2·`div_i` cycles after the rising edge that samples the last response bit. The valid strobe is high in that same cycle.
- R9: In continuous mode with a byte pending, the select stays low. The valid strobe and the new byte's bit 7 both appear `div_i` cycles after the last sampling edge, on the falling edge.
- R10: In continuous mode with no byte pending at the end of a frame, the frame closes exactly as in R8.
- R11: Between single frames the select stays high for a full half-period. With the next byte already waiting, the high time is exactly `div_i` + 1 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| div_i | input | DIV_W | Serial half-period in system cycles |
| resp_len_i | input | 5 | Response length in bits (clamped 4..16) |
| cont_i | input | 1 | Continuous mode enable |
| cmd_valid_i | input | 1 | Control byte available |
| cmd_byte_i | input | 8 | Control byte |
| cmd_ready_o | output | 1 | Control byte accepted when high with valid |
| sdi_i | input | 1 | Serial data from slave |
| sclk_o | output | 1 | Serial clock |
| fsel_no | output | 1 | Active-low frame select |
| sdo_o | output | 1 | Serial data to slave |
| rsp_word_o | output | 16 | Received response, right-aligned |
| rsp_valid_o | output | 1 | One-cycle strobe for rsp_word_o |

## Verification
A bench slave model watches the serial clock. It drives response bits after falling edges and records the transmit line on rising edges. It counts system cycles between every pair of serial events, so the `div_i` spacing of R3 is measured on every edge rather than at fixed sample points. The strobe is expected 2·`div_i` cycles after the last sampling edge for a closing frame and `div_i` cycles after it for a chained one. The bench measures this distance directly from the recorded edge cycle. Select and data after an accepted byte are checked exactly one cycle after the accepting edge. All outputs are sampled on the falling system-clock edge.

// File: rtl/hdx_pkg.sv
package hdx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_TAIL = 2'd2,
    ST_GAP  = 2'd3
  } hdx_state_e;
endpackage

// File: rtl/hdx_half_timer.sv
module hdx_half_timer #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q, cnt_d, div_eff;

  assign div_eff = (div_i == '0) ? DIV_W'(1) : div_i;
  assign tick_o  = run_i && (cnt_q == div_eff - 1'b1);

  always_comb begin
    if (!run_i || tick_o) cnt_d = '0;
    else                  cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  // R3: the count advances by one per cycle inside a half-period
  a_r3_count_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !tick_o) |=> (!run_i || cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/hdx_tx_shift.sv
module hdx_tx_shift #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] byte_i,
  input  logic         shift_i,
  input  logic         stop_i,
  output logic         sdo_o
);
  logic [W-1:0] sr_q, sr_d;
  logic         on_q, on_d;

  always_comb begin
    sr_d = sr_q;
    on_d = on_q;
    if (load_i) begin
      sr_d = byte_i;
      on_d = 1'b1;
    end else begin
      if (shift_i) sr_d = {sr_q[W-2:0], 1'b0};
      if (stop_i)  on_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q <= '0;
      on_q <= 1'b0;
    end else begin
      sr_q <= sr_d;
      on_q <= on_d;
    end
  end

  assign sdo_o = on_q & sr_q[W-1];

  // R2: the byte's MSB reaches the line one cycle after loading
  a_r2_msb_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (sdo_o == $past(byte_i[W-1])));
endmodule

// File: rtl/hdx_rx_shift.sv
module hdx_rx_shift #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clear_i,
  input  logic         sample_i,
  input  logic         sdi_i,
  output logic [W-1:0] data_o
);
  logic [W-1:0] data_q, data_d;

  always_comb begin
    data_d = data_q;
    if (clear_i)       data_d = '0;
    else if (sample_i) data_d = {data_q[W-2:0], sdi_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) data_q <= '0;
    else         data_q <= data_d;
  end

  assign data_o = data_q;

  // R5: no sampling at a frame start edge
  a_r5_clear_sample_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |-> !sample_i);
endmodule

// File: rtl/hdx_serial_master.sv
module hdx_serial_master
  import hdx_pkg::*;
#(
  parameter int DIV_W    = 8,
  parameter int CTRL_W   = 8,
  parameter int RESP_MIN = 4,
  parameter int RESP_MAX = 16
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [DIV_W-1:0]             div_i,
  input  logic [$clog2(RESP_MAX+1)-1:0] resp_len_i,
  input  logic                         cont_i,
  input  logic                         cmd_valid_i,
  input  logic [CTRL_W-1:0]            cmd_byte_i,
  output logic                         cmd_ready_o,
  input  logic                         sdi_i,
  output logic                         sclk_o,
  output logic                         fsel_no,
  output logic                         sdo_o,
  output logic [RESP_MAX-1:0]          rsp_word_o,
  output logic                         rsp_valid_o
);
  localparam int LEN_W = $clog2(RESP_MAX + 1);
  localparam int HC_W  = $clog2(2 * (CTRL_W + 1 + RESP_MAX));
  localparam logic [HC_W-1:0] CTRL_LAST_HALF = HC_W'(2 * CTRL_W - 1);
  localparam logic [HC_W-1:0] RESP_FIRST_H   = HC_W'(2 * (CTRL_W + 1));

  function automatic logic [LEN_W-1:0] clamp_len(input logic [LEN_W-1:0] l);
    if (l < LEN_W'(RESP_MIN)) return LEN_W'(RESP_MIN);
    if (l > LEN_W'(RESP_MAX)) return LEN_W'(RESP_MAX);
    return l;
  endfunction

  hdx_state_e          state_q, state_d;
  logic [HC_W-1:0]     hcnt_q, hcnt_d, last_half;
  logic                sclk_q, sclk_d, fsel_q, fsel_d, vld_q, vld_d;
  logic [LEN_W-1:0]    len_q, len_d, len_eff;
  logic [RESP_MAX-1:0] word_q, word_d, rx_data;
  logic                tick, in_run, at_last, chain, accept;
  logic                tx_shift, tx_stop, rx_sample;

  assign len_eff   = clamp_len(resp_len_i);
  assign last_half = HC_W'({len_q, 1'b0}) + HC_W'(2 * CTRL_W + 1);
  assign in_run    = (state_q == ST_RUN);
  assign at_last   = in_run && (hcnt_q == last_half);
  assign chain     = at_last && tick && cont_i && cmd_valid_i;

  assign cmd_ready_o = (state_q == ST_IDLE) || (at_last && tick && cont_i);
  assign accept      = cmd_valid_i && cmd_ready_o;

  assign tx_shift  = in_run && tick && hcnt_q[0] && (hcnt_q < CTRL_LAST_HALF);
  assign tx_stop   = in_run && tick && (hcnt_q == CTRL_LAST_HALF);
  assign rx_sample = in_run && tick && !hcnt_q[0] && (hcnt_q >= RESP_FIRST_H);

  hdx_half_timer #(.DIV_W(DIV_W)) timer_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (state_q != ST_IDLE),
    .div_i  (div_i),
    .tick_o (tick)
  );

  hdx_tx_shift #(.W(CTRL_W)) tx_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (accept),
    .byte_i  (cmd_byte_i),
    .shift_i (tx_shift),
    .stop_i  (tx_stop),
    .sdo_o   (sdo_o)
  );

  hdx_rx_shift #(.W(RESP_MAX)) rx_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clear_i  (accept),
    .sample_i (rx_sample),
    .sdi_i    (sdi_i),
    .data_o   (rx_data)
  );

  always_comb begin
    state_d = state_q;
    hcnt_d  = hcnt_q;
    sclk_d  = sclk_q;
    fsel_d  = fsel_q;
    len_d   = len_q;
    vld_d   = 1'b0;
    word_d  = word_q;
    unique case (state_q)
      ST_IDLE: begin
        if (cmd_valid_i) begin
          state_d = ST_RUN;
          hcnt_d  = '0;
          fsel_d  = 1'b0;
          len_d   = len_eff;
        end
      end
      ST_RUN: begin
        if (tick) begin
          if (at_last) begin
            sclk_d = 1'b0;
            if (chain) begin
              hcnt_d = '0;
              len_d  = len_eff;
              vld_d  = 1'b1;
              word_d = rx_data;
            end else begin
              state_d = ST_TAIL;
            end
          end else begin
            hcnt_d = hcnt_q + 1'b1;
            sclk_d = ~hcnt_q[0];
          end
        end
      end
      ST_TAIL: begin
        if (tick) begin
          fsel_d  = 1'b1;
          vld_d   = 1'b1;
          word_d  = rx_data;
          state_d = ST_GAP;
        end
      end
      ST_GAP: begin
        if (tick) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      hcnt_q  <= '0;
      sclk_q  <= 1'b0;
      fsel_q  <= 1'b1;
      len_q   <= LEN_W'(RESP_MIN);
      vld_q   <= 1'b0;
      word_q  <= '0;
    end else begin
      state_q <= state_d;
      hcnt_q  <= hcnt_d;
      sclk_q  <= sclk_d;
      fsel_q  <= fsel_d;
      len_q   <= len_d;
      vld_q   <= vld_d;
      word_q  <= word_d;
    end
  end

  assign sclk_o      = sclk_q;
  assign fsel_no     = fsel_q;
  assign rsp_word_o  = word_q;
  assign rsp_valid_o = vld_q;

  // R1: quiet lines while idle
  a_r1_idle_lines: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE) |-> (!sclk_q && fsel_q && !sdo_o && !vld_q));
  // R5: transmit line low once the control byte has gone
  a_r5_sdo_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_run && hcnt_q >= CTRL_LAST_HALF + 1'b1) |-> !sdo_o);
  // R3: serial clock moves only on a half-period tick
  a_r3_sclk_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sclk_q) |-> $past(tick));
  // R6: half counter never passes the frame length
  a_r6_hcnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_run |-> (hcnt_q <= last_half));
  // R8: a strobe with the select high coincides with its release
  a_r8_valid_on_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_q && fsel_q) |-> $rose(fsel_q));
  // R9: a strobe with the select low marks a chained restart
  a_r9_chain_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_q && !fsel_q) |-> (in_run && hcnt_q == '0 && !sclk_q));
endmodule

// File: tb/hdx_serial_master_tb_top.sv
module hdx_serial_master_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  div;
  logic [4:0]  rlen;
  logic        cont, cvalid, cready, sdi, sclk, fsel_n, sdo, rvalid;
  logic [7:0]  cbyte;
  logic [15:0] rword;

  always #5 clk = ~clk;

  hdx_serial_master dut_i (
    .clk_i(clk), .rst_ni(rst_n), .div_i(div), .resp_len_i(rlen), .cont_i(cont),
    .cmd_valid_i(cvalid), .cmd_byte_i(cbyte), .cmd_ready_o(cready), .sdi_i(sdi),
    .sclk_o(sclk), .fsel_no(fsel_n), .sdo_o(sdo), .rsp_word_o(rword),
    .rsp_valid_o(rvalid)
  );

  typedef struct packed {
    logic [3:0]  d;
    logic [4:0]  l;
    logic [7:0]  c;
    logic [15:0] r;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{4'd1, 5'd4,  8'hA5, 16'h000B},
    '{4'd2, 5'd8,  8'h3C, 16'h00C3},
    '{4'd3, 5'd16, 8'h81, 16'hBEEF},
    '{4'd1, 5'd13, 8'hFF, 16'h1234},
    '{4'd4, 5'd5,  8'h00, 16'h0015},
    '{4'd1, 5'd2,  8'h5A, 16'h0006},
    '{4'd2, 5'd20, 8'hC3, 16'h8001},
    '{4'd0, 5'd7,  8'hE7, 16'hFFFF}
  };

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // slave model / monitor state
  int cyc, rise_n, fall_n, evt_cyc, last_rise_cyc, fsel_rise_cyc, last_gap;
  int valid_n, got_lat, fr_rises, sl_idx, cur_div, sl_len;
  logic [7:0]  ctrl_cap, fr_ctrl;
  logic [15:0] got_word;
  logic [15:0] sl_resp [4];
  logic sclk_p, fsel_p, got_fsel, half_bad, sdo_bad, idle_bad;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic int clampl(input int l);
    if (l < 4)  return 4;
    if (l > 16) return 16;
    return l;
  endfunction

  always @(negedge clk) begin
    cyc++;
    if (!rst_n) begin
      sdi = 1'b1; rise_n = 0; fall_n = 0; evt_cyc = cyc; valid_n = 0;
      sclk_p = 1'b0; fsel_p = 1'b1; fsel_rise_cyc = cyc; sl_idx = 0;
    end else begin
      if (fsel_p && !fsel_n) begin
        evt_cyc = cyc; rise_n = 0; fall_n = 0; last_gap = cyc - fsel_rise_cyc;
      end
      if (!fsel_p && fsel_n) begin
        fsel_rise_cyc = cyc;
        if (cyc - evt_cyc != cur_div) half_bad = 1'b1;
      end
      if (fsel_n && (sclk || sdo)) idle_bad = 1'b1;
      if (!fsel_n && sclk && !sclk_p) begin
        if (cyc - evt_cyc != cur_div) half_bad = 1'b1;
        evt_cyc = cyc; rise_n++; last_rise_cyc = cyc;
        if (rise_n <= 8) ctrl_cap = {ctrl_cap[6:0], sdo};
        else if (sdo) sdo_bad = 1'b1;
      end
      if (!fsel_n && !sclk && sclk_p) begin
        if (cyc - evt_cyc != cur_div) half_bad = 1'b1;
        evt_cyc = cyc; fall_n++;
        if (fall_n >= 9 && fall_n <= 8 + sl_len)
          sdi = sl_resp[sl_idx % 4][sl_len - 1 - (fall_n - 9)];
        else
          sdi = 1'b1;
        if (fall_n == 9 + sl_len) begin
          fr_rises = rise_n; fr_ctrl = ctrl_cap;
          rise_n = 0; fall_n = 0; sl_idx++;
        end
      end
      if (rvalid) begin
        valid_n++; got_word = rword; got_lat = cyc - last_rise_cyc; got_fsel = fsel_n;
      end
      sclk_p = sclk; fsel_p = fsel_n;
    end
  end

  task automatic push(input logic [7:0] b);
    @(negedge clk);
    cvalid = 1'b1; cbyte = b;
    while (!cready) @(negedge clk);
    @(negedge clk);
    cvalid = 1'b0;
    chk("R2 select low after accept", fsel_n, 0);
    chk("R2 msb on line after accept", sdo, b[7]);
  endtask

  task automatic wait_valid(input int n);
    while (valid_n < n) @(posedge clk);
  endtask

  task automatic setup(input int d, input int l, input logic c);
    @(posedge clk);
    div = 8'(d); rlen = 5'(l); cont = c;
    cur_div = (d == 0) ? 1 : d; sl_len = clampl(l);
    half_bad = 1'b0; sdo_bad = 1'b0; idle_bad = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; div = 8'd1; rlen = 5'd4; cont = 1'b0; cvalid = 1'b0; cbyte = '0;
    cur_div = 1; sl_len = 4; half_bad = 0; sdo_bad = 0; idle_bad = 0;
    for (int k = 0; k < 4; k++) sl_resp[k] = '0;
    repeat (3) @(negedge clk);
    chk("R1 reset sclk", sclk, 0);
    chk("R1 reset select", fsel_n, 1);
    chk("R1 reset sdo", sdo, 0);
    chk("R1 reset valid", rvalid, 0);
    chk("R2 ready when idle", cready, 1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int i = 0; i < 8; i++) begin
      int n0, nn;
      setup(VECS[i].d, VECS[i].l, 1'b0);
      nn = clampl(VECS[i].l);
      for (int k = 0; k < 4; k++) sl_resp[k] = VECS[i].r;
      n0 = valid_n;
      push(VECS[i].c);
      wait_valid(n0 + 1);
      chk("R7 word right aligned", got_word, VECS[i].r & ((1 << nn) - 1));
      chk("R4 control byte msb first", fr_ctrl, VECS[i].c);
      chk("R6 rising edges per frame", fr_rises, 9 + nn);
      chk("R8 strobe latency", got_lat, 2 * cur_div);
      chk("R8 select high at strobe", got_fsel, 1);
      chk("R5 sdo low after control", sdo_bad, 0);
      chk("R3 half period spacing", half_bad, 0);
      repeat (2 * cur_div + 4) @(negedge clk);
      chk("R1 quiet lines between frames", idle_bad, 0);
    end

    // R9: chained frames in continuous mode
    begin
      int n0;
      setup(2, 6, 1'b1);
      sl_resp[sl_idx % 4] = 16'h0029;
      sl_resp[(sl_idx + 1) % 4] = 16'h0016;
      n0 = valid_n;
      push(8'h96);
      push(8'h3B);
      wait_valid(n0 + 1);
      chk("R9 first word", got_word, 16'h0029);
      chk("R9 strobe one half after lsb", got_lat, 2);
      chk("R9 select held low", got_fsel, 0);
      chk("R9 first control byte", fr_ctrl, 8'h96);
      wait_valid(n0 + 2);
      chk("R9 second word", got_word, 16'h0016);
      chk("R9 second control byte", fr_ctrl, 8'h3B);
      chk("R10 final frame closes", got_fsel, 1);
      chk("R3 spacing across chain", half_bad, 0);
      repeat (10) @(negedge clk);
    end

    // R10: continuous mode, nothing pending
    begin
      int n0;
      setup(3, 4, 1'b1);
      for (int k = 0; k < 4; k++) sl_resp[k] = 16'h000A;
      n0 = valid_n;
      push(8'h11);
      wait_valid(n0 + 1);
      chk("R10 word", got_word, 16'h000A);
      chk("R10 strobe latency", got_lat, 6);
      chk("R10 select high", got_fsel, 1);
      repeat (12) @(negedge clk);
    end

    // R11: back-to-back single frames, next byte waiting
    begin
      int n0;
      setup(2, 4, 1'b0);
      for (int k = 0; k < 4; k++) sl_resp[k] = 16'h0005;
      n0 = valid_n;
      push(8'h42);
      push(8'h24);
      @(posedge clk);
      chk("R11 select high gap", last_gap, 3);
      wait_valid(n0 + 2);
      chk("R11 second word", got_word, 16'h0005);
      chk("R11 second control byte", fr_ctrl, 8'h24);
    end

    repeat (10) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule